// File: doc/BRIEF.md
# I2C Master Byte Clocking and Stop Control

This block is the control core of a bus master for a two-wire open-drain serial bus. Software commands a start, writes bytes to be sent or received, and finally asks for a stop. The block clocks each byte as eight data clocks plus a ninth acknowledge clock. Between bytes it holds the clock line low in a wait period until software acts. An optional extra wait can be placed between the eighth and ninth clocks.

A stop request is checked against the current state before it is taken. It is honoured only while the block is master, only inside a wait, never in the same cycle as a start command, and during reception only when acknowledge generation is off. A request that arrives in the extra wait after the eighth clock turns the ninth clock into the stop itself: SCL rises once more, and SDA is released while SCL is high. The pending-stop status bit is cleared by any of five sources: the stop seen on the bus, arbitration loss, an exit command, disabling the block, or reset.

The block drives the lines only through pull-down enables and reads the resolved line levels back. It clears its master status when it sees a stop on the bus.

Top module: `i2c_master_stop`

## Requirements
- R1: After reset, both pull-down enables are 0, and `stop_req`, `master`, `waiting` and `stop_seen` are 0.
- R2: A start command is taken only when the block is enabled, not master, idle and both lines read high. SDA falls while SCL is high, and the block then waits with SCL held low and `master` set. A start command while master has no effect on the bus.
- R3: Each released byte gives exactly nine SCL rising edges. On the first eight, SDA carries the written byte most significant bit first (a 0 bit means SDA is driven low). Each SCL phase lasts HALF_CYC cycles.
- R4: With `wait9` = 0, the block stops after the eighth rising edge and holds SCL low until a data write releases the ninth clock. It always waits after the ninth clock.
- R5: A stop command while the block is not master is ignored: `stop_req` stays 0 and no stop appears.
- R6: A stop command in the same cycle as a start command is ignored.
- R7: A stop command while a byte is being clocked, or outside a wait, is ignored.
- R8: While the last byte was a reception (`tx_in` = 0 when it was written), a stop is accepted only with `ack_en` = 0. In that case the ninth clock leaves SDA released (not-acknowledge).
- R9: A stop accepted in the wait after the start or after the ninth clock drives SDA low with SCL low for HALF_CYC cycles. It then releases SCL, and HALF_CYC cycles after SCL rises it releases SDA. This gives exactly one stop.
- R10: A stop accepted in the wait after the eighth clock produces exactly one more SCL rising edge (the ninth clock). SDA rises during that high phase and forms the stop.
- R11: `stop_req` returns to 0 after the stop is seen on the bus, and one cycle after an arbitration-loss pulse, an exit command, or `en` = 0.
- R12: A second stop command while `stop_req` is 1 is ignored and produces no second stop.
- R13: An arbitration-loss pulse or an exit command releases both lines and clears `master` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Block enable; 0 stops operation |
| ack_en | input | 1 | Drive acknowledge on the ninth clock when receiving |
| wait9 | input | 1 | 1: wait only after the ninth clock; 0: also wait after the eighth |
| tx_in | input | 1 | Direction for the byte written by `dat_wr` (1 transmit, 0 receive) |
| cmd_start | input | 1 | Start command pulse |
| cmd_stop | input | 1 | Stop command pulse |
| cmd_exit | input | 1 | Leave the transfer and release the bus |
| dat_wr | input | 1 | Shift register write pulse; releases a wait |
| dat_in | input | DATA_W | Byte to send |
| arb_lost | input | 1 | Arbitration-loss pulse |
| scl_in | input | 1 | Resolved SCL level |
| sda_in | input | 1 | Resolved SDA level |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| stop_req | output | 1 | Stop request pending |
| master | output | 1 | Block owns the bus |
| xmit | output | 1 | Current byte is a transmission |
| waiting | output | 1 | Block is in a wait with SCL held low |
| stop_seen | output | 1 | One-cycle pulse after a stop on the bus |

## Verification
The assertions check the acceptance rules on every cycle. Each time `stop_req` is set, the cycle before must show master mode, a wait, no start command, and either a transmission or acknowledge disabled. They also check that every clearing source empties `stop_req` one cycle later, and that arbitration loss or exit leaves both lines released. Only the bench scenarios, with a pull-up model of both lines, can show the bus waveforms. These are the clock count per byte and the bit order, the pause after the eighth clock, the exact SCL-to-SDA gap of the stop, the single extra clock when the stop is taken in the eighth-clock wait, and that rejected or repeated requests leave the bus with no added stop.

// File: rtl/i2cm_pkg.sv
// Shared types for the I2C master stop controller.
package i2cm_pkg;
    // Controller state; the waits are the only states that accept a stop.
    typedef enum logic [3:0] {
        ST_IDLE,   // bus released
        ST_STA,    // SDA low, SCL high: start hold
        ST_WTS,    // wait after start, SCL low
        ST_BLO,    // bit clock, SCL low phase
        ST_BHI,    // bit clock, SCL high phase
        ST_WT8,    // wait after eighth clock
        ST_WT9,    // wait after ninth clock
        ST_PLO,    // stop: SDA low, SCL low
        ST_PHI     // stop: SDA low, SCL high
    } i2cm_state_e;
endpackage

// File: rtl/i2cm_half_timer.sv
// Half-bit phase timer. It reloads on every state change and reports
// done once the phase has lasted HALF_CYC cycles. Assumes HALF_CYC >= 2.
module i2cm_half_timer #(
    parameter int HALF_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic done
);
    localparam int CW = $clog2(HALF_CYC + 1);
    localparam logic [CW-1:0] RELOAD = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt;

    // Count down from the reload value and hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            cnt <= RELOAD;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

    a_r3_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= RELOAD);
endmodule

// File: rtl/i2cm_stop_detect.sv
// Bus monitor. It flags a stop (SDA rising while SCL stays high) from the
// resolved line levels. Assumes the line inputs are synchronous to clk.
module i2cm_stop_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic det
);
    logic scl_q;
    logic sda_q;

    // Keep last cycle's line levels; reset to released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_in;
            sda_q <= sda_in;
        end
    end

    assign det = scl_q & scl_in & ~sda_q & sda_in;
endmodule

// File: rtl/i2cm_stop_req.sv
// Stop request gate and status bit. It accepts a stop command only under
// the legal conditions and clears the bit from any clearing source.
// Clearing wins over a same-cycle accept.
module i2cm_stop_req (
    input  logic clk,
    input  logic rst_n,
    input  logic req,        // stop command pulse
    input  logic start_req,  // start command pulse, same cycle
    input  logic en,
    input  logic is_master,
    input  logic in_wait,
    input  logic xmit,
    input  logic ack_en,
    input  logic clr,        // arbitration loss, exit, disable or bus stop
    output logic pending,
    output logic go
);
    logic accept;

    // Legal acceptance: master, in a wait, no start, nothing pending, and
    // a reception only with acknowledge off.
    always_comb begin
        accept = req & ~start_req & en & is_master & in_wait & ~pending
                 & (xmit | ~ack_en);
        go     = accept & ~clr;
    end

    // Status bit: clear has priority over set.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pending <= 1'b0;
        end else if (accept) begin
            pending <= 1'b1;
        end
    end

    a_r5_only_master: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> $past(is_master));
    a_r6_not_with_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> !$past(start_req));
    a_r7_only_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> $past(in_wait));
    a_r8_rx_needs_nack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> $past(xmit || !ack_en));
    a_r11_clear_sources: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !pending);
endmodule

// File: rtl/i2c_master_stop.sv
// I2C master byte clocking and stop controller. It clocks 8 data bits and
// an acknowledge bit per byte, waits with SCL low after the ninth clock
// (and optionally after the eighth), and produces start and stop
// conditions. Lines are open drain: the *_oe outputs pull low, and the
// *_in inputs are the resolved levels, assumed synchronous to clk.
module i2c_master_stop #(
    parameter int HALF_CYC = 8,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              ack_en,
    input  logic              wait9,
    input  logic              tx_in,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic              cmd_exit,
    input  logic              dat_wr,
    input  logic [DATA_W-1:0] dat_in,
    input  logic              arb_lost,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              stop_req,
    output logic              master,
    output logic              xmit,
    output logic              waiting,
    output logic              stop_seen
);
    import i2cm_pkg::*;

    localparam int BCW = $clog2(DATA_W + 2);
    localparam logic [BCW-1:0] LAST_DATA = BCW'(DATA_W - 1);
    localparam logic [BCW-1:0] ACK_BIT   = BCW'(DATA_W);

    i2cm_state_e       st, nxt;
    logic [BCW-1:0]    bcnt;
    logic [DATA_W-1:0] sh;
    logic              trc, mst, tdone, tload, stop_go, det;
    logic              in_wait, drop, start_ok, clr;

    assign in_wait  = (st == ST_WTS) || (st == ST_WT8) || (st == ST_WT9);
    assign drop     = arb_lost | cmd_exit | ~en;
    assign clr      = drop | det;
    assign start_ok = cmd_start & en & ~cmd_stop & ~mst & (st == ST_IDLE)
                      & scl_in & sda_in;
    assign tload    = (nxt != st);

    i2cm_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tload),
        .done  (tdone)
    );

    i2cm_stop_detect u_det (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .det    (det)
    );

    i2cm_stop_req u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (cmd_stop),
        .start_req (cmd_start),
        .en        (en),
        .is_master (mst),
        .in_wait   (in_wait),
        .xmit      (trc),
        .ack_en    (ack_en),
        .clr       (clr),
        .pending   (stop_req),
        .go        (stop_go)
    );

    // Next-state selection; drop forces the idle state.
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE: if (start_ok) nxt = ST_STA;
            ST_STA:  if (tdone) nxt = ST_WTS;
            ST_WTS, ST_WT8, ST_WT9: begin
                if (stop_go) nxt = ST_PLO;
                else if (dat_wr) nxt = ST_BLO;
            end
            ST_BLO:  if (tdone) nxt = ST_BHI;
            ST_BHI: begin
                if (tdone) begin
                    if (bcnt == ACK_BIT) nxt = ST_WT9;
                    else if (bcnt == LAST_DATA && !wait9) nxt = ST_WT8;
                    else nxt = ST_BLO;
                end
            end
            ST_PLO:  if (tdone) nxt = ST_PHI;
            ST_PHI:  if (tdone) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
        if (drop) nxt = ST_IDLE;
    end

    // State, bit counter, shift register and direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            bcnt <= '0;
            sh   <= '0;
            trc  <= 1'b0;
        end else begin
            st <= nxt;
            if (st == ST_IDLE && nxt == ST_STA) begin
                trc <= 1'b1;
            end
            if ((st == ST_WTS || st == ST_WT9) && nxt == ST_BLO) begin
                sh   <= dat_in;
                trc  <= tx_in;
                bcnt <= '0;
            end
            if (st == ST_BHI && nxt == ST_BLO) begin
                bcnt <= bcnt + 1'b1;
                sh   <= {sh[DATA_W-2:0], 1'b1};
            end
            if (st == ST_BHI && nxt == ST_WT8) begin
                bcnt <= bcnt + 1'b1;
            end
        end
    end

    // Master ownership: set by the start, cleared by a bus stop or drop.
    always_ff @(posedge clk) begin
        if (!rst_n || drop || det) begin
            mst <= 1'b0;
        end else if (st == ST_IDLE && nxt == ST_STA) begin
            mst <= 1'b1;
        end
    end

    // Registered pulse after a stop on the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) stop_seen <= 1'b0;
        else        stop_seen <= det;
    end

    // Line pull-down enables decoded from the state.
    always_comb begin
        scl_oe = (st == ST_WTS) || (st == ST_WT8) || (st == ST_WT9)
                 || (st == ST_BLO) || (st == ST_PLO);
        unique case (st)
            ST_STA, ST_WTS, ST_PLO, ST_PHI: sda_oe = 1'b1;
            ST_BLO, ST_BHI: begin
                if (bcnt == ACK_BIT) sda_oe = ~trc & ack_en;
                else                 sda_oe = trc & ~sh[DATA_W-1];
            end
            default: sda_oe = 1'b0;
        endcase
    end

    assign master  = mst;
    assign xmit    = trc;
    assign waiting = in_wait;

    a_r13_drop_release: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_lost || cmd_exit) |=> (!scl_oe && !sda_oe && !master));
    a_r2_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(master) |-> $past(scl_in && sda_in && !stop_req));
    a_r10_wait8_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(stop_req) && $past(st == ST_WT8)) |-> (scl_oe && sda_oe));
    a_r4_wait_holds_scl: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && $past(waiting) && !dat_wr) |-> scl_oe);
endmodule

// File: tb/tb_i2c_master_stop.sv
module tb_i2c_master_stop;
    localparam int HALF = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, en, ack_en, wait9, tx_in;
    logic cmd_start, cmd_stop, cmd_exit, dat_wr, arb_lost;
    logic [7:0] dat_in;
    logic scl_oe, sda_oe, stop_req, master, xmit, waiting, stop_seen;

    wire bus_scl = ~scl_oe;   // pull-up resolution
    wire bus_sda = ~sda_oe;

    i2c_master_stop #(.HALF_CYC(HALF), .DATA_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .ack_en(ack_en), .wait9(wait9),
        .tx_in(tx_in), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
        .cmd_exit(cmd_exit), .dat_wr(dat_wr), .dat_in(dat_in),
        .arb_lost(arb_lost), .scl_in(bus_scl), .sda_in(bus_sda),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .stop_req(stop_req),
        .master(master), .xmit(xmit), .waiting(waiting),
        .stop_seen(stop_seen)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // Bus monitor: counts SCL rises, starts and stops, captures SDA bits.
    int cyc = 0, rises = 0, stops = 0, starts = 0, rise_cyc = 0, gap = 0;
    logic [15:0] cap = '0;
    logic p_scl = 1'b1, p_sda = 1'b1;
    always @(posedge clk) begin
        #2;
        cyc++;
        if (bus_scl && !p_scl) begin
            rises++;
            rise_cyc = cyc;
            cap = {cap[14:0], bus_sda};
        end
        if (bus_scl && p_scl && bus_sda && !p_sda) begin
            stops++;
            gap = cyc - rise_cyc;
        end
        if (bus_scl && p_scl && !bus_sda && p_sda) starts++;
        p_scl = bus_scl;
        p_sda = bus_sda;
    end

    function automatic int exp_rises(input bit stop_in_wait8);
        return stop_in_wait8 ? 1 : 9;
    endfunction

    task automatic chkeq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_for_wait;
        for (int i = 0; i < 400 && !waiting; i++) step();
    endtask

    task automatic wait_idle;
        for (int i = 0; i < 400 && master; i++) step();
        step(2);
    endtask

    task automatic begin_xfer;
        cmd_start = 1'b1; step(); cmd_start = 1'b0;
        wait_for_wait();
    endtask

    task automatic pulse_stop;
        cmd_stop = 1'b1; step(); cmd_stop = 1'b0;
    endtask

    // Send one byte; checks the clock count and bit order (R3, R4).
    task automatic send_byte(input logic [7:0] d, input bit w9, input bit rx);
        int r0;
        wait9 = w9; tx_in = ~rx; dat_in = d; r0 = rises;
        dat_wr = 1'b1; step(); dat_wr = 1'b0;
        wait_for_wait();
        if (!w9) begin
            chkeq("R4 rises at eighth-clock wait", rises - r0, 8);
            step(3);
            chkeq("R4 SCL held in eighth-clock wait", rises - r0 + int'(bus_scl), 8);
            dat_wr = 1'b1; step(); dat_wr = 1'b0;
            wait_for_wait();
        end
        chkeq("R3 clocks per byte", rises - r0, exp_rises(1'b0));
        chkeq("R3 data bits msb first", int'(cap[8:1]), rx ? 8'hFF : int'(d));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL R3 watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int s0, r0;
        void'($urandom(32'h5eed_1234));
        rst_n = 0; en = 1; ack_en = 1; wait9 = 1; tx_in = 1;
        cmd_start = 0; cmd_stop = 0; cmd_exit = 0; dat_wr = 0;
        dat_in = 0; arb_lost = 0;
        step(4); rst_n = 1; step();

        // R1 reset state
        chkeq("R1 scl_oe", scl_oe, 0);
        chkeq("R1 sda_oe", sda_oe, 0);
        chkeq("R1 stop_req", stop_req, 0);
        chkeq("R1 master", master, 0);
        chkeq("R1 waiting", waiting, 0);
        chkeq("R1 stop_seen", stop_seen, 0);

        // R5 stop while not master
        pulse_stop(); step(5);
        chkeq("R5 stop_req idle", stop_req, 0);
        chkeq("R5 no stop idle", stops, 0);

        // R2 start
        begin_xfer();
        chkeq("R2 one start", starts, 1);
        chkeq("R2 master", master, 1);
        chkeq("R2 waiting", waiting, 1);
        chkeq("R2 scl held low", bus_scl, 0);
        cmd_start = 1; step(); cmd_start = 0; step(3);
        chkeq("R2 start while master ignored", starts, 1);

        // R6 stop with start
        cmd_start = 1; cmd_stop = 1; step(); cmd_start = 0; cmd_stop = 0;
        chkeq("R6 stop_req", stop_req, 0);
        chkeq("R6 still waiting", waiting, 1);

        // R7 stop during byte
        tx_in = 1; dat_in = 8'hA5; wait9 = 1; r0 = rises;
        dat_wr = 1; step(); dat_wr = 0; step(6);
        pulse_stop();
        chkeq("R7 stop_req mid byte", stop_req, 0);
        wait_for_wait();
        chkeq("R7 byte completes", rises - r0, 9);
        chkeq("R3 data A5", int'(cap[8:1]), 8'hA5);
        chkeq("R7 no stop", stops, 0);

        // R8 reception, then R9 and R12
        ack_en = 1;
        send_byte(8'h00, 1'b1, 1'b1);
        chkeq("R8 ack driven on ninth", int'(cap[0]), 0);
        pulse_stop();
        chkeq("R8 stop rejected with ack on", stop_req, 0);
        ack_en = 0;
        send_byte(8'h00, 1'b1, 1'b1);
        chkeq("R8 nack on ninth", int'(cap[0]), 1);
        s0 = stops;
        pulse_stop();
        chkeq("R8 stop accepted with ack off", stop_req, 1);
        chkeq("R9 sda low first", sda_oe, 1);
        chkeq("R9 scl low first", scl_oe, 1);
        pulse_stop();  // R12 second request
        wait_idle();
        chkeq("R12 exactly one stop", stops - s0, 1);
        chkeq("R9 scl-to-sda gap", gap, HALF);
        chkeq("R11 cleared by bus stop", stop_req, 0);
        chkeq("R9 lines released", int'(scl_oe) + int'(sda_oe), 0);
        ack_en = 1;

        // R10 stop in the eighth-clock wait
        begin_xfer();
        wait9 = 0; tx_in = 1; dat_in = 8'h3C;
        dat_wr = 1; step(); dat_wr = 0;
        wait_for_wait();
        s0 = stops; r0 = rises;
        pulse_stop();
        chkeq("R10 accepted", stop_req, 1);
        wait_idle();
        chkeq("R10 one more clock", rises - r0, exp_rises(1'b1));
        chkeq("R10 one stop", stops - s0, 1);
        wait9 = 1;

        // R11 and R13 arbitration loss after an accepted stop
        begin_xfer();
        send_byte(8'h5A, 1'b1, 1'b0);
        pulse_stop();
        chkeq("R11 pending before loss", stop_req, 1);
        arb_lost = 1; step(); arb_lost = 0;
        chkeq("R11 cleared by arbitration loss", stop_req, 0);
        chkeq("R13 master dropped", master, 0);
        chkeq("R13 lines released", int'(scl_oe) + int'(sda_oe), 0);
        step(3);

        // R13 exit command
        begin_xfer();
        cmd_exit = 1; step(); cmd_exit = 0;
        chkeq("R13 exit master", master, 0);
        chkeq("R13 exit lines", int'(scl_oe) + int'(sda_oe), 0);
        step(3);

        // R11 disable after an accepted stop
        begin_xfer();
        pulse_stop();
        chkeq("R9 stop from start wait", stop_req, 1);
        en = 0; step(); en = 1;
        chkeq("R11 cleared by disable", stop_req, 0);
        chkeq("R11 disable drops master", master, 0);
        step(3);

        // Random transactions
        for (int t = 0; t < 40; t++) begin
            int nb;
            bit rx_end;
            nb = 1 + int'($urandom % 3);
            rx_end = bit'($urandom % 2);
            begin_xfer();
            for (int b = 0; b < nb; b++) begin
                send_byte(8'($urandom), bit'($urandom % 2), 1'b0);
            end
            if (rx_end) begin
                ack_en = 0;
                send_byte(8'h00, bit'($urandom % 2), 1'b1);
                chkeq("R8 random nack", int'(cap[0]), 1);
            end
            s0 = stops;
            pulse_stop();
            chkeq("R9 random accept", stop_req, 1);
            wait_idle();
            chkeq("R9 random one stop", stops - s0, 1);
            chkeq("R9 random gap", gap, HALF);
            chkeq("R11 random clear", stop_req, 0);
            ack_en = 1;
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule